// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Controller

This block keeps one direct-mapped, write-back cache coherent with its peers on a shared bus. Each line carries a tag, one data word and a coherence state: Invalid, Shared (clean, and possibly held by other caches as well) or Exclusive (written, and this cache holds the only copy). The processor port takes read and write requests. A request that can be served from the line completes in the same cycle. Any other request goes out on the bus. The bus is a single-grant interface: a request is presented and held, and the grant cycle is the whole atomic transaction.

The bus-side snoop port watches the misses of other caches. A snooped write miss invalidates a matching line. When a snooped miss matches a line held Exclusive, this cache supplies the dirty word and raises an abort, so that memory does not answer.

The control sequencer has four named states. `CS_IDLE` serves hits and detects misses. `CS_EVICT` writes back an Exclusive victim whose tag conflicts with the request. `CS_MISS` holds a read-miss or write-miss transaction until it is granted. `CS_DONE` returns the result. Its transitions are:
- IDLE→EVICT on a miss whose victim is Exclusive.
- IDLE→MISS on any other miss.
- EVICT→MISS when the write-back is granted, or when a snoop has taken the victim out of Exclusive.
- MISS→DONE on the grant.
- DONE→IDLE always.

Top module: `snoop_wi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid. The first access to any address misses, and no snoop raises `snp_abort`.
- R2: A read whose line is Shared or Exclusive with a matching tag completes in the request cycle. In that cycle `cpu_ready`=1, `cpu_hit`=1 and `cpu_rdata` carries the line word. `bus_req` stays low.
- R3: A read miss keeps `cpu_ready` low and requests `bus_cmd`=01 (read miss) at the request address, starting the cycle after the request. On the grant the line takes `bus_rdata` and becomes Shared. In the next cycle `cpu_ready`=1, `cpu_hit`=0 and `cpu_rdata` carries that word.
- R4: A write to a line that is Invalid, holds another tag, or is Shared with the same tag requests `bus_cmd`=10 (write miss). No separate upgrade transaction is used. On the grant the line becomes Exclusive with the write data, and `cpu_ready` rises in the next cycle.
- R5: A write to an Exclusive line with a matching tag completes in the request cycle with `cpu_hit`=1 and no bus activity. A later read returns the new word.
- R6: A miss on an index held Exclusive under another tag first requests `bus_cmd`=11 (write-back), with the victim address and word. After that grant the line is Invalid, and the miss is requested in the next cycle.
- R7: A snoop with `snp_cmd`=1 (write miss) that matches a Shared line gives no abort and invalidates the line.
- R8: A snoop with `snp_cmd`=0 (read miss) that matches an Exclusive line raises `snp_abort` in the same cycle, drives the word on `snp_data`, and leaves the line Shared. A matching Shared line is left unchanged, with no abort.
- R9: A snoop with `snp_cmd`=1 that matches an Exclusive line raises `snp_abort`, supplies the word, and then invalidates the line.
- R10: While a bus request waits for its grant, `cpu_ready` stays low, and `bus_cmd` and `bus_addr` hold steady. Snoops are still answered during this wait.
- R11: A snoop to the same index as a processor request that arrives in the idle state stalls that request for the cycle (`cpu_ready`=0). The snoop takes effect first.
- R12: If a snoop removes the victim from Exclusive before its write-back is granted, the write-back is dropped and the miss is requested directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address (low IDX_W bits are the index) |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Completed without the bus |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 01 read miss, 10 write miss, 11 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back or write-miss data |
| bus_gnt | input | 1 | Grant: the transaction completes this cycle |
| bus_rdata | input | DATA_W | Fill word, valid with the grant |
| snp_valid | input | 1 | Another cache's miss is on the bus |
| snp_cmd | input | 1 | 0 read miss, 1 write miss |
| snp_addr | input | ADDR_W | Snooped address |
| snp_abort | output | 1 | This cache supplies the data; memory must not respond |
| snp_data | output | DATA_W | Supplied dirty word |

## Verification
- **Hits and snoop answers:** a hit and a snoop answer (`snp_abort` and `snp_data`) are combinational. The bench samples them 1 ns after driving the inputs at the falling edge, before the next rising edge.
- **Bus requests:** a bus request first appears one rising edge after a missing request. The bench watches for it at each following falling edge and raises the grant there.
- **Completion:** `cpu_ready` with the filled word is due one edge after the granted edge.
- **State changes:** a snoop's effect on line state is visible from the next edge. The bench updates its model at that edge and observes the effect through the following access.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BOP_NONE   = 2'd0,
        BOP_RDMISS = 2'd1,
        BOP_WRMISS = 2'd2,
        BOP_WBACK  = 2'd3
    } bus_op_t;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_EVICT = 2'd1,
        CS_MISS  = 2'd2,
        CS_DONE  = 2'd3
    } ctl_st_t;

endpackage

// File: rtl/cc_line_store.sv
module cc_line_store
    import cc_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    // processor-side read port
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_t          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    // processor-side write port (hit, fill, eviction)
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  line_st_t          wa_st,
    input  logic [TAG_W-1:0]  wa_tag,
    input  logic [DATA_W-1:0] wa_data,
    // snoop-side read port
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_t          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    // snoop-side state-only write port
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  line_st_t          wb_st
);

    localparam int LINES = 1 << IDX_W;

    line_st_t          st_w  [LINES];
    logic [TAG_W-1:0]  tag_w [LINES];
    logic [DATA_W-1:0] dat_w [LINES];

    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(gi);
        line_st_t          st_r;
        logic [TAG_W-1:0]  tag_r;
        logic [DATA_W-1:0] dat_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_r  <= LS_INV;
                tag_r <= '0;
                dat_r <= '0;
            end else if (wa_en && wa_idx == MY_IDX) begin
                st_r  <= wa_st;
                tag_r <= wa_tag;
                dat_r <= wa_data;
            end else if (wb_en && wb_idx == MY_IDX) begin
                st_r  <= wb_st;
            end
        end

        assign st_w[gi]  = st_r;
        assign tag_w[gi] = tag_r;
        assign dat_w[gi] = dat_r;
    end

    assign a_st   = st_w[a_idx];
    assign a_tag  = tag_w[a_idx];
    assign a_data = dat_w[a_idx];
    assign b_st   = st_w[b_idx];
    assign b_tag  = tag_w[b_idx];
    assign b_data = dat_w[b_idx];

    // R11
    port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en) |-> (wa_idx != wb_idx));

endmodule

// File: rtl/cc_snoop_unit.sv
module cc_snoop_unit
    import cc_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              snp_valid,
    input  logic              snp_is_wr,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_t          line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              abort,
    output logic [DATA_W-1:0] supply,
    output logic              upd_en,
    output line_st_t          upd_st
);

    logic match;

    always_comb begin
        match  = snp_valid && (line_st != LS_INV) && (line_tag == snp_tag);
        abort  = 1'b0;
        supply = '0;
        upd_en = 1'b0;
        upd_st = line_st;
        if (match) begin
            unique case (line_st)
                LS_EXC: begin
                    abort  = 1'b1;
                    supply = line_data;
                    upd_en = 1'b1;
                    upd_st = snp_is_wr ? LS_INV : LS_SHR;
                end
                LS_SHR: begin
                    if (snp_is_wr) begin
                        upd_en = 1'b1;
                        upd_st = LS_INV;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/snoop_wi_cache_ctrl.sv
module snoop_wi_cache_ctrl
    import cc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_abort,
    output logic [DATA_W-1:0] snp_data
);

    localparam int TAG_W = ADDR_W - IDX_W;

    ctl_st_t cs_q, cs_d;

    logic              req_we_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [TAG_W-1:0]  vic_tag_q;

    logic [IDX_W-1:0]  cpu_idx, req_idx, snp_idx, a_idx;
    logic [TAG_W-1:0]  cpu_tag, req_tag, snp_tag;

    line_st_t          a_st, b_st, wa_st, upd_st;
    logic [TAG_W-1:0]  a_tag, b_tag, wa_tag;
    logic [DATA_W-1:0] a_data, b_data, wa_data;
    logic              wa_en, upd_en;

    logic    stall, tag_eq, local_hit, go_miss, need_wb, victim_live;
    bus_op_t bus_op;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign req_idx = req_addr_q[IDX_W-1:0];
    assign req_tag = req_addr_q[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
    assign a_idx   = (cs_q == CS_IDLE) ? cpu_idx : req_idx;

    cc_line_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_idx  (a_idx),
        .a_st   (a_st),
        .a_tag  (a_tag),
        .a_data (a_data),
        .wa_en  (wa_en),
        .wa_idx (a_idx),
        .wa_st  (wa_st),
        .wa_tag (wa_tag),
        .wa_data(wa_data),
        .b_idx  (snp_idx),
        .b_st   (b_st),
        .b_tag  (b_tag),
        .b_data (b_data),
        .wb_en  (upd_en),
        .wb_idx (snp_idx),
        .wb_st  (upd_st)
    );

    cc_snoop_unit #(
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_snoop (
        .snp_valid(snp_valid),
        .snp_is_wr(snp_cmd),
        .snp_tag  (snp_tag),
        .line_st  (b_st),
        .line_tag (b_tag),
        .line_data(b_data),
        .abort    (snp_abort),
        .supply   (snp_data),
        .upd_en   (upd_en),
        .upd_st   (upd_st)
    );

    // request classification in the idle state
    always_comb begin
        stall       = snp_valid && (snp_idx == cpu_idx);
        tag_eq      = (a_tag == cpu_tag);
        local_hit   = cpu_req && !stall &&
                      (cpu_we ? (a_st == LS_EXC && tag_eq)
                              : (a_st != LS_INV && tag_eq));
        go_miss     = cpu_req && !stall && !local_hit;
        need_wb     = (a_st == LS_EXC) && !tag_eq;
        victim_live = (a_st == LS_EXC) && (a_tag == vic_tag_q);
    end

    // next-state logic
    always_comb begin
        cs_d = cs_q;
        unique case (cs_q)
            CS_IDLE:  if (go_miss) cs_d = need_wb ? CS_EVICT : CS_MISS;
            CS_EVICT: if (!victim_live || bus_gnt) cs_d = CS_MISS;
            CS_MISS:  if (bus_gnt) cs_d = CS_DONE;
            CS_DONE:  cs_d = CS_IDLE;
            default:  cs_d = CS_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q        <= CS_IDLE;
            req_we_q    <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            rdata_q     <= '0;
            vic_tag_q   <= '0;
        end else begin
            cs_q <= cs_d;
            if (cs_q == CS_IDLE && go_miss) begin
                req_we_q    <= cpu_we;
                req_addr_q  <= cpu_addr;
                req_wdata_q <= cpu_wdata;
                vic_tag_q   <= a_tag;
            end
            if (cs_q == CS_MISS && bus_gnt) begin
                rdata_q <= req_we_q ? req_wdata_q : bus_rdata;
            end
        end
    end

    // outputs and line updates
    always_comb begin
        cpu_ready = 1'b0;
        cpu_hit   = 1'b0;
        cpu_rdata = a_data;
        bus_op    = BOP_NONE;
        bus_addr  = req_addr_q;
        bus_wdata = req_wdata_q;
        wa_en     = 1'b0;
        wa_st     = a_st;
        wa_tag    = a_tag;
        wa_data   = a_data;
        unique case (cs_q)
            CS_IDLE: begin
                if (local_hit) begin
                    cpu_ready = 1'b1;
                    cpu_hit   = 1'b1;
                    if (cpu_we) begin
                        wa_en   = 1'b1;
                        wa_st   = LS_EXC;
                        wa_tag  = cpu_tag;
                        wa_data = cpu_wdata;
                    end
                end
            end
            CS_EVICT: begin
                if (victim_live) begin
                    bus_op    = BOP_WBACK;
                    bus_addr  = {vic_tag_q, req_idx};
                    bus_wdata = a_data;
                    if (bus_gnt) begin
                        wa_en = 1'b1;
                        wa_st = LS_INV;
                    end
                end
            end
            CS_MISS: begin
                bus_op = req_we_q ? BOP_WRMISS : BOP_RDMISS;
                if (bus_gnt) begin
                    wa_en   = 1'b1;
                    wa_st   = req_we_q ? LS_EXC : LS_SHR;
                    wa_tag  = req_tag;
                    wa_data = req_we_q ? req_wdata_q : bus_rdata;
                end
            end
            CS_DONE: begin
                cpu_ready = 1'b1;
                cpu_rdata = rdata_q;
            end
            default: ;
        endcase
    end

    assign bus_req = (bus_op != BOP_NONE);
    assign bus_cmd = bus_op;

    // R2 R5
    hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_hit) |-> !bus_req);

    // R10
    wait_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cpu_ready);

    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid) |=>
            (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

    // R10
    gnt_snoop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |-> (bus_req && !snp_valid));

    // R3 R4
    fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_req && bus_op != BOP_WBACK) |=> (cpu_ready && !cpu_hit));

    // R6
    wb_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_op == BOP_WBACK) |=> (bus_req && bus_op != BOP_WBACK));

    // R8 R9
    abort_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_abort |-> snp_valid);

endmodule

// File: tb/sim_snoop_wi_cache_ctrl.sv
`timescale 1ns/1ps
module sim_snoop_wi_cache_ctrl;

    localparam int ST_INV = 0;
    localparam int ST_SHR = 1;
    localparam int ST_EXC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0;
    logic       cpu_ready, cpu_hit;
    logic [7:0] cpu_rdata;
    logic       bus_req;
    logic [1:0] bus_cmd;
    logic [7:0] bus_addr, bus_wdata;
    logic       bus_gnt = 1'b0;
    logic [7:0] bus_rdata = '0;
    logic       snp_valid = 1'b0, snp_cmd = 1'b0;
    logic [7:0] snp_addr = '0;
    logic       snp_abort;
    logic [7:0] snp_data;

    int checks = 0;
    int fails = 0;

    int         ex_st  [16];
    logic [3:0] ex_tag [16];
    logic [7:0] ex_dat [16];
    logic [7:0] mem    [256];

    always #2.5 clk = ~clk;

    snoop_wi_cache_ctrl #(.ADDR_W(8), .IDX_W(4), .DATA_W(8)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_abort(snp_abort), .snp_data(snp_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_hit(input bit we, input logic [7:0] a);
        int i = int'(a[3:0]);
        if (we) return ex_st[i] == ST_EXC && ex_tag[i] == a[7:4];
        return ex_st[i] != ST_INV && ex_tag[i] == a[7:4];
    endfunction

    function automatic bit exp_wb(input logic [7:0] a);
        int i = int'(a[3:0]);
        return ex_st[i] == ST_EXC && ex_tag[i] != a[7:4];
    endfunction

    // caller stands at a falling edge; returns at a falling edge
    task automatic do_snoop(input bit c, input logic [7:0] a);
        int  i  = int'(a[3:0]);
        bit  m  = ex_st[i] != ST_INV && ex_tag[i] == a[7:4];
        bit  ab = m && ex_st[i] == ST_EXC;
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        chk(snp_abort == ab, c ? "R9 snoop abort" : "R8 snoop abort", int'(snp_abort), int'(ab));
        if (ab) chk(snp_data == ex_dat[i], c ? "R9 snoop data" : "R8 snoop data",
                    int'(snp_data), int'(ex_dat[i]));
        @(posedge clk);
        if (ab) mem[a] = ex_dat[i];
        if (m) begin
            if (c) ex_st[i] = ST_INV;
            else if (ex_st[i] == ST_EXC) ex_st[i] = ST_SHR;
        end
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic cpu_access(input bit we, input logic [7:0] a, input logic [7:0] wd,
                              input bit snp_en, input bit snp_c, input logic [7:0] snp_a,
                              input int gdelay);
        int  i = int'(a[3:0]);
        bit  done = 0;
        bit  snooped = 0;
        int  waited = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        if (exp_hit(we, a)) begin
            chk(cpu_ready && cpu_hit, we ? "R5 hit ready" : "R2 hit ready",
                int'({cpu_ready, cpu_hit}), 3);
            chk(!bus_req, we ? "R5 no bus" : "R2 no bus", int'(bus_req), 0);
            if (!we) chk(cpu_rdata == ex_dat[i], "R2 hit data", int'(cpu_rdata), int'(ex_dat[i]));
            @(posedge clk);
            if (we) ex_dat[i] = wd;
            @(negedge clk);
            cpu_req = 1'b0;
            return;
        end
        chk(!cpu_ready, we ? "R4 miss stalls" : "R3 miss stalls", int'(cpu_ready), 0);
        @(negedge clk);
        for (int k = 0; k < 30 && !done; k++) begin
            if (snp_en && !snooped) begin
                snooped = 1;
                #1;
                chk(!cpu_ready, "R10 ready low during snoop", int'(cpu_ready), 0);
                do_snoop(snp_c, snp_a);
            end else begin
                #1;
                if (cpu_ready) begin
                    chk(!cpu_hit, we ? "R4 done no hit" : "R3 done no hit", int'(cpu_hit), 0);
                    chk(cpu_rdata == ex_dat[i], we ? "R4 done data" : "R3 done data",
                        int'(cpu_rdata), int'(ex_dat[i]));
                    @(posedge clk);
                    @(negedge clk);
                    cpu_req = 1'b0;
                    done = 1;
                end else if (bus_req) begin
                    logic [1:0] ecmd;
                    logic [7:0] eaddr;
                    bit wb = exp_wb(a);
                    ecmd  = wb ? 2'b11 : (we ? 2'b10 : 2'b01);
                    eaddr = wb ? {ex_tag[i], a[3:0]} : a;
                    chk(bus_cmd == ecmd, wb ? "R6 cmd" : (we ? "R4 cmd" : "R3 cmd"),
                        int'(bus_cmd), int'(ecmd));
                    chk(bus_addr == eaddr, wb ? "R6 addr" : "R10 addr",
                        int'(bus_addr), int'(eaddr));
                    if (wb) chk(bus_wdata == ex_dat[i], "R6 wdata", int'(bus_wdata), int'(ex_dat[i]));
                    if (waited < gdelay) begin
                        waited++;
                        @(negedge clk);
                    end else begin
                        waited = 0;
                        bus_gnt = 1'b1;
                        bus_rdata = mem[a];
                        @(posedge clk);
                        if (wb) begin
                            mem[eaddr] = ex_dat[i];
                            ex_st[i] = ST_INV;
                        end else begin
                            ex_st[i]  = we ? ST_EXC : ST_SHR;
                            ex_tag[i] = a[7:4];
                            ex_dat[i] = we ? wd : mem[a];
                        end
                        @(negedge clk);
                        bus_gnt = 1'b0;
                    end
                end else begin
                    @(negedge clk);
                end
            end
        end
        chk(done, "R10 access completes", int'(done), 1);
        cpu_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4021));
        for (int k = 0; k < 256; k++) mem[k] = 8'(k) ^ 8'h5A;
        for (int k = 0; k < 16; k++) begin
            ex_st[k] = ST_INV; ex_tag[k] = '0; ex_dat[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(!bus_req && !cpu_ready, "R1 quiet after reset", int'({bus_req, cpu_ready}), 0);
        do_snoop(1'b0, 8'h00);   // R1 no abort from empty cache

        // R3 then R2
        cpu_access(0, 8'h13, 8'h00, 0, 0, 8'h00, 0);
        cpu_access(0, 8'h13, 8'h00, 0, 0, 8'h00, 0);
        // R4 write to Shared, then R5 write hit
        cpu_access(1, 8'h13, 8'hA1, 0, 0, 8'h00, 1);
        cpu_access(1, 8'h13, 8'hA2, 0, 0, 8'h00, 0);
        cpu_access(0, 8'h13, 8'h00, 0, 0, 8'h00, 0);
        // R8 read-miss snoop on Exclusive, then again on Shared
        do_snoop(1'b0, 8'h13);
        do_snoop(1'b0, 8'h13);
        cpu_access(0, 8'h13, 8'h00, 0, 0, 8'h00, 0);
        // R9 write-miss snoop on Exclusive, then a read misses
        cpu_access(1, 8'h13, 8'hB3, 0, 0, 8'h00, 0);
        do_snoop(1'b1, 8'h13);
        cpu_access(0, 8'h13, 8'h00, 0, 0, 8'h00, 0);
        // R7 write-miss snoop on Shared
        cpu_access(0, 8'h24, 8'h00, 0, 0, 8'h00, 0);
        do_snoop(1'b1, 8'h24);
        cpu_access(0, 8'h24, 8'h00, 0, 0, 8'h00, 0);
        // R6 eviction of a dirty victim
        cpu_access(1, 8'h15, 8'hC5, 0, 0, 8'h00, 0);
        cpu_access(0, 8'h25, 8'h00, 0, 0, 8'h00, 2);
        cpu_access(0, 8'h15, 8'h00, 0, 0, 8'h00, 0);
        // R12 victim taken by a snoop while waiting
        cpu_access(1, 8'h16, 8'hD6, 0, 0, 8'h00, 0);
        cpu_access(0, 8'h26, 8'h00, 1, 1, 8'h16, 0);
        // R10 snoop serviced during a delayed grant
        cpu_access(1, 8'h19, 8'hE9, 0, 0, 8'h00, 0);
        cpu_access(0, 8'h37, 8'h00, 1, 0, 8'h19, 3);
        // R11 snoop to the same index as a write hit
        cpu_access(1, 8'h18, 8'h78, 0, 0, 8'h00, 0);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h18; cpu_wdata = 8'h79;
        snp_valid = 1'b1; snp_cmd = 1'b0; snp_addr = 8'h18;
        #1;
        chk(!cpu_ready, "R11 stalled by snoop", int'(cpu_ready), 0);
        chk(snp_abort, "R11 snoop served first", int'(snp_abort), 1);
        chk(snp_data == ex_dat[8], "R11 snoop data", int'(snp_data), int'(ex_dat[8]));
        @(posedge clk);
        mem[8'h18] = ex_dat[8];
        ex_st[8] = ST_SHR;
        @(negedge clk);
        cpu_req = 1'b0; snp_valid = 1'b0;
        cpu_access(1, 8'h18, 8'h79, 0, 0, 8'h00, 0);

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom % 10);
            logic [7:0] a  = {4'($urandom % 3), 4'($urandom % 4)};
            logic [7:0] sa = {4'($urandom % 3), 4'($urandom % 4)};
            logic [7:0] wd = 8'($urandom);
            bit se = ($urandom % 4) == 0;
            bit sc = 1'($urandom);
            int gd = int'($urandom % 3);
            if (r < 4)      cpu_access(0, a, wd, se, sc, sa, gd);
            else if (r < 7) cpu_access(1, a, wd, se, sc, sa, gd);
            else            do_snoop(sc, a);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule